// File: doc/BRIEF.md
# Bidirectional GPIO Port Register Block

This block is an 8-bit general-purpose I/O port for a microcontroller peripheral bus. It holds two registers. The direction register picks, pin by pin, whether the pad is driven or only observed. The data register holds the values that driven pins put out. Software reaches both through a small register bus. That bus has a one-bit address, a write strobe, a read strobe and 8-bit write and read data.

Reading the data address returns the stored bit for every pin set to drive. For every pin set to observe, it returns the pin level after synchronization. The direction register cannot be read back: its address always reads as all ones. Bit position 6 has no pad. Its data bit is a plain storage bit, and it never drives or samples anything.

Two standby inputs change how the port behaves. Hardware standby disables every driver at once and clears both registers. Software standby leaves the port exactly as it was, so driven pins keep their levels.

Top module: `gpio_port_regs`

## Requirements
- R1: A direction bit of 1 makes the matching pin driven (`pin_oe` bit high, `pin_out` bit equal to the stored data bit). A direction bit of 0 leaves the pin undriven (`pin_oe` bit low).
- R2: A read with `bus_addr` = 1 (direction register) returns 8'hFF whatever the direction register holds.
- R3: After synchronous reset, both registers hold 8'h00, `pin_oe` and `pin_out` are 8'h00, and a data read with all pins low returns 8'h00.
- R4: While `hw_stby` is high, `pin_oe` is 8'h00 in the same cycle. Both registers are cleared at the next rising edge. Writes made while it is high are discarded.
- R5: `sw_stby` has no effect: register contents, `pin_oe`, `pin_out` and writes behave as if it were low.
- R6: A read with `bus_addr` = 0 (data register) returns, per bit, the stored data bit where the direction bit is 1 and the synchronized pin level where it is 0.
- R7: Bit 6 has no pin. `pin_oe[6]` and `pin_out[6]` are always 0. Its data bit can be written and read back, and a data read always returns the stored bit there, whatever `pin_in[6]` or direction bit 6 are.
- R8: A change on `pin_in` appears on a data read after the second rising edge following the change, and not after the first.
- R9: A write lands on the rising edge where `wr_stb` is high. A read in that same cycle returns the value from before the write.
- R10: While `rd_stb` is low, `rdata` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_stby | input | 1 | Hardware standby: disables drivers, clears registers |
| sw_stby | input | 1 | Software standby: port keeps its state |
| bus_addr | input | 1 | Register select: 0 data, 1 direction |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |

## Verification
Two things can fall in the same cycle: a register write and a read of the same register, or a write and a hardware-standby request. The bench checks both. In the first case it holds `wr_stb` and `rd_stb` high together, and `rdata` must show the old contents before the edge and the new contents after it. In the second case it raises `hw_stby` in the very cycle it writes the data register, and the stored value must be 8'h00 afterwards. `pin_oe` must drop before the edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic {
    ADDR_DATA = 1'b0,
    ADDR_DIR  = 1'b1
  } port_addr_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= pin_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
    // R8: each stage passes its predecessor on one cycle later
    a_r8_stage_shift: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> stage_q[s] == $past(stage_q[s-1]));
  end

  // R8: first stage captures the pads one cycle later
  a_r8_first_stage: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> stage_q[0] == $past(pin_in));

  assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg #(
  parameter int WIDTH = 8,
  parameter int NOPIN = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hw_stby,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] KEEP_MASK = ~(WIDTH'(1) << NOPIN);

  always_ff @(posedge clk) begin
    if (rst || hw_stby) q <= '0;
    else if (we)        q <= wdata & KEEP_MASK;
  end

  // R4: hardware standby empties the direction register
  a_r4_dir_hw_clear: assert property (@(posedge clk) disable iff (rst)
    hw_stby |=> q == '0);
  // R5: without a write the direction register holds, standby or not
  a_r5_dir_hold: assert property (@(posedge clk) disable iff (rst)
    (!we && !hw_stby) |=> $stable(q));
endmodule

// File: rtl/gpio_data_reg.sv
module gpio_data_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hw_stby,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || hw_stby) q <= '0;
    else if (we)        q <= wdata;
  end

  // R9: an accepted write is visible after its edge
  a_r9_data_commit: assert property (@(posedge clk) disable iff (rst)
    (we && !hw_stby) |=> q == $past(wdata));
  // R4: hardware standby empties the data register
  a_r4_data_hw_clear: assert property (@(posedge clk) disable iff (rst)
    hw_stby |=> q == '0);
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int NOPIN       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hw_stby,
  input  logic             sw_stby,
  input  logic             bus_addr,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  localparam logic [WIDTH-1:0] NOPIN_BIT = WIDTH'(1) << NOPIN;
  localparam logic [WIDTH-1:0] PIN_MASK  = ~NOPIN_BIT;

  logic [WIDTH-1:0] dir_q, data_q, pin_s, sel_latch;
  logic             dir_we, data_we, stby_unused;

  // software standby intentionally leaves the port untouched
  assign stby_unused = sw_stby;

  assign dir_we  = wr_stb && (port_addr_e'(bus_addr) == ADDR_DIR);
  assign data_we = wr_stb && (port_addr_e'(bus_addr) == ADDR_DATA);

  gpio_dir_reg #(.WIDTH(WIDTH), .NOPIN(NOPIN)) u_dir (
    .clk(clk), .rst(rst), .hw_stby(hw_stby),
    .we(dir_we), .wdata(wdata), .q(dir_q)
  );

  gpio_data_reg #(.WIDTH(WIDTH)) u_data (
    .clk(clk), .rst(rst), .hw_stby(hw_stby),
    .we(data_we), .wdata(wdata), .q(data_q)
  );

  gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in), .pin_sync(pin_s)
  );

  assign sel_latch = dir_q | NOPIN_BIT;

  always_comb begin
    rdata = '0;
    if (rd_stb) begin
      if (port_addr_e'(bus_addr) == ADDR_DIR) rdata = '1;
      else rdata = (sel_latch & data_q) | (~sel_latch & pin_s);
    end
  end

  assign pin_oe  = hw_stby ? '0 : (dir_q & PIN_MASK);
  assign pin_out = data_q & PIN_MASK;

  // R4: a driver seen in the cycle after standby began means the clear failed
  a_r4_oe_after_stby: assert property (@(posedge clk) disable iff (rst)
    $past(hw_stby) |-> dir_q == '0);
endmodule

// File: tb/gpio_port_regs_bench.sv
`timescale 1ns/1ps
module gpio_port_regs_bench;
  logic       clk = 1'b0;
  logic       rst, hw_stby, sw_stby, bus_addr, wr_stb, rd_stb;
  logic [7:0] wdata, rdata, pin_in, pin_out, pin_oe;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port_regs u_gpio_port_regs (
    .clk(clk), .rst(rst), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .bus_addr(bus_addr), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // {dir, data, pin, expected read, expected oe, expected out}
  localparam logic [47:0] VEC [8] = '{
    {8'h00, 8'h00, 8'hA5, 8'hA5, 8'h00, 8'h00},
    {8'hFF, 8'h3C, 8'h00, 8'h3C, 8'hBF, 8'h3C},
    {8'hF0, 8'h5A, 8'h0F, 8'h5F, 8'hB0, 8'h1A},
    {8'h0F, 8'hC3, 8'hF0, 8'hF3, 8'h0F, 8'h83},
    {8'h40, 8'h40, 8'h00, 8'h40, 8'h00, 8'h00},
    {8'h00, 8'h00, 8'h40, 8'h00, 8'h00, 8'h00},
    {8'hAA, 8'hFF, 8'h55, 8'hFF, 8'hAA, 8'hBF},
    {8'h55, 8'h00, 8'hFF, 8'hAA, 8'h15, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; wdata = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic read(input logic a, output logic [7:0] d);
    bus_addr = a; rd_stb = 1'b1;
    #0.5 d = rdata;
    rd_stb = 1'b0;
  endtask

  initial begin
    #1000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    rst = 1'b1; hw_stby = 0; sw_stby = 0; bus_addr = 0;
    wr_stb = 0; rd_stb = 0; wdata = 0; pin_in = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R3 reset state
    read(1'b0, r); check("R3 data", r, 8'h00);
    check("R3 oe", pin_oe, 8'h00);
    check("R3 out", pin_out, 8'h00);
    // R10 idle read bus
    #0.5 check("R10 idle rdata", rdata, 8'h00);

    // R1 R6 R7 vector table
    foreach (VEC[i]) begin
      write(1'b1, VEC[i][47:40]);
      write(1'b0, VEC[i][39:32]);
      pin_in = VEC[i][31:24];
      @(negedge clk); @(negedge clk);
      read(1'b0, r);
      check("R6 R7 read", r, VEC[i][23:16]);
      check("R1 R7 oe", pin_oe, VEC[i][15:8]);
      check("R1 R7 out", pin_out, VEC[i][7:0]);
      read(1'b1, r);
      check("R2 dir read", r, 8'hFF);
    end

    // R8 latency: dir all input
    write(1'b1, 8'h00);
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    pin_in = 8'h3C;
    @(negedge clk);
    read(1'b0, r); check("R8 after one edge", r, 8'h00);
    @(negedge clk);
    read(1'b0, r); check("R8 after two edges", r, 8'h3C);

    // R9 same-cycle write and read
    pin_in = 8'h00;
    write(1'b1, 8'hFF);
    write(1'b0, 8'h11);
    @(negedge clk);
    bus_addr = 1'b0; wdata = 8'h22; wr_stb = 1'b1; rd_stb = 1'b1;
    #0.5 check("R9 read before edge", rdata, 8'h11);
    @(negedge clk);
    wr_stb = 1'b0;
    #0.5 check("R9 read after edge", rdata, 8'h22);
    rd_stb = 1'b0;

    // R5 software standby keeps everything
    write(1'b1, 8'hF0);
    write(1'b0, 8'hA5);
    sw_stby = 1'b1;
    repeat (4) @(negedge clk);
    check("R5 oe held", pin_oe, 8'hB0);
    check("R5 out held", pin_out, 8'hA5);
    write(1'b0, 8'h81);
    check("R5 write works", pin_out, 8'h81);
    sw_stby = 1'b0;

    // R4 hardware standby with a write in the same cycle
    write(1'b1, 8'hFF);
    write(1'b0, 8'h3C);
    @(negedge clk);
    hw_stby = 1'b1; bus_addr = 1'b0; wdata = 8'h77; wr_stb = 1'b1;
    #0.5 check("R4 oe off at once", pin_oe, 8'h00);
    @(negedge clk);
    wr_stb = 1'b0;
    @(negedge clk);
    hw_stby = 1'b0;
    check("R4 out cleared", pin_out, 8'h00);
    write(1'b1, 8'hFF);
    read(1'b0, r); check("R4 data cleared, write dropped", r, 8'h00);

    // R10 read strobe low during a data-address selection
    write(1'b0, 8'h5A);
    bus_addr = 1'b0;
    #0.5 check("R10 no strobe", rdata, 8'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule